// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller watches up to 32 request lines and turns their transitions into latched interrupt requests and single-clock event pulses. Each line is brought into the clock domain by a two-flop synchronizer. An edge line has an edge detector that can fire on rising edges, on falling edges, or on both. A detected edge sets a sticky pending flag, and software clears that flag by writing 1 to it. A level-follow ("direct") line has no edge configuration. Its synchronized level goes straight to its interrupt output through the mask, and the mask resets to enabled. Lines that are neither kind are reserved: their bits read as 0 and writes to them are ignored.

Software reaches six word registers through a single-cycle synchronous port. The registers are the interrupt enable, event enable, rising select, falling select, software trigger and pending flags. `addr_i` is the word index; byte offsets are four times the index. A software trigger sets a pending flag without any edge on the line. An edge that coincides with a bus write to either select register is discarded, so a line that is being reconfigured cannot latch a spurious request.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the interrupt enable register reads as the direct-line mask and every other register reads 0. `irq_o` and `evt_o` are 0 while the lines are low.
- R2: The registers are selected by word index on `addr_i`: 0 interrupt enable, 1 event enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending. The enable registers keep only edge and direct bits. The select, trigger and pending registers keep only edge bits. Indexes 6 and 7 read 0 and ignore writes.
- R3: On an edge line, a rising edge sets pending when the rising-select bit is 1, and a falling edge sets pending when the falling-select bit is 1. With both bits set, either edge sets pending. The flag is visible in the third clock edge after the line changes.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R5: `irq_o` of an edge line is its pending bit ANDed with its interrupt enable bit. Clearing the enable hides the request but keeps the flag.
- R6: `evt_o` pulses for exactly one clock on every selected edge or software trigger whose event enable bit is 1, whatever the interrupt enable bit is.
- R7: An edge detected in the same cycle as a bus write to the rising or falling select register does not set pending and gives no event. A write to any other register does not suppress the edge.
- R8: Writing 1 to a software-trigger bit that reads 0 sets that bit. It also sets pending if the interrupt enable bit is 1, and pulses the event if the event enable bit is 1, all in the same clock. Writing 1 to a bit that already reads 1 has no effect.
- R9: A software-trigger bit clears when a 1 is written to its pending bit.
- R10: On a direct line, `irq_o` follows the synchronized level ANDed with the interrupt enable, two clock edges after the line changes. `evt_o` pulses once on each rising level when events are enabled. The pending bit reads 0.
- R11: `rdata_o` loads the addressed register at the clock edge of a read and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_LINES | Asynchronous request lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | N_LINES | Write data |
| rdata_o | output | N_LINES | Read data, valid the cycle after a read |
| irq_o | output | N_LINES | Per-line interrupt request |
| evt_o | output | N_LINES | Per-line one-clock event pulse |

## Verification
The bench sweeps all four select combinations, using two line patterns that cover every edge, direct and reserved bit together. A design with a swapped edge polarity, or with an event that lasts more than one clock, fails the cycle-exact samples at the second and third edge. The bench places a select-register write in the exact cycle the edge is detected and expects the edge to be lost. It repeats the timing with a write to the event enable register and expects the edge to be kept, so a design that drops edges on every write is also caught. A write of 0 to the pending register must leave the flags intact. Software trigger bits are rewritten while they already read 1, and then cleared through the pending register. A design that re-fires on a second write, or keeps the trigger bit after its flag is cleared, gives wrong read-back values.

// File: rtl/edge_irq_pkg.sv
`timescale 1ns/1ps
package edge_irq_pkg;
  typedef enum logic [2:0] {
    REG_IMASK  = 3'd0,
    REG_EMASK  = 3'd1,
    REG_RISE   = 3'd2,
    REG_FALL   = 3'd3,
    REG_SWTRIG = 3'd4,
    REG_PEND   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
`timescale 1ns/1ps
module eirq_detect #(
  parameter int unsigned         W           = 32,
  parameter logic [W-1:0]        EDGE_MASK   = '1,
  parameter logic [W-1:0]        DIRECT_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] sel_wr_i,
  input  logic [W-1:0] sw_wr_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] imask_i,
  input  logic [W-1:0] emask_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] sw_o,
  output logic [W-1:0] irq_o,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, pend_q, sw_q, evt_q;
  logic [W-1:0] rise_v, fall_v, hw_trig, sw_set;

  assign rise_v  = lvl_i & ~prev_q;
  assign fall_v  = ~lvl_i & prev_q;
  // select writes mask out edges seen in the same cycle
  assign hw_trig = ((rise_v & rise_en_i) | (fall_v & fall_en_i)) & ~sel_wr_i & EDGE_MASK;
  assign sw_set  = sw_wr_i & ~sw_q & EDGE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
      sw_q   <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | hw_trig | (sw_set & imask_i);
      sw_q   <= (sw_q & ~clr_i) | (sw_wr_i & EDGE_MASK);
      evt_q  <= ((hw_trig | sw_set) & emask_i) | (rise_v & emask_i & DIRECT_MASK);
    end
  end

  assign pend_o = pend_q;
  assign sw_o   = sw_q;
  assign evt_o  = evt_q;
  assign irq_o  = (pend_q & imask_i) | (lvl_i & imask_i & DIRECT_MASK);

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_PEND_NEEDS_TRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(rise_en_i[i] | fall_en_i[i] | (sw_wr_i[i] & imask_i[i]))); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !rise_en_i[i] && !fall_en_i[i] && !sw_wr_i[i] |=> !pend_q[i]); // R4
    AST_EVT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[i] |-> $past(emask_i[i])); // R6
    AST_SEL_WRITE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_wr_i[i] && !sw_wr_i[i] && !pend_q[i] |=> !pend_q[i]); // R7
    AST_SW_CLEARED_BY_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_o[i]) |-> $past(clr_i[i])); // R9
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned         N_LINES     = 32,
  parameter logic [N_LINES-1:0]  EDGE_MASK   = 32'h00FF_FFFF,
  parameter logic [N_LINES-1:0]  DIRECT_MASK = 32'h0F00_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] rdata_o,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] evt_o
);
  localparam logic [N_LINES-1:0] EN_WR_MASK = EDGE_MASK | DIRECT_MASK;

  logic [N_LINES-1:0] lvl, imask_q, emask_q, rise_q, fall_q, pend, swtrig;
  logic [N_LINES-1:0] sel_wr, sw_wr, clr;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  eirq_sync #(.W(N_LINES), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= DIRECT_MASK;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        REG_IMASK: imask_q <= wdata_i & EN_WR_MASK;
        REG_EMASK: emask_q <= wdata_i & EN_WR_MASK;
        REG_RISE:  rise_q  <= wdata_i & EDGE_MASK;
        REG_FALL:  fall_q  <= wdata_i & EDGE_MASK;
        default: ;
      endcase
    end
  end

  assign sel_wr = {N_LINES{wr && (addr_i == REG_RISE || addr_i == REG_FALL)}};
  assign sw_wr  = (wr && addr_i == REG_SWTRIG) ? wdata_i : '0;
  assign clr    = (wr && addr_i == REG_PEND)   ? wdata_i : '0;

  eirq_detect #(.W(N_LINES), .EDGE_MASK(EDGE_MASK), .DIRECT_MASK(DIRECT_MASK)) i_detect (
    .clk_i, .rst_ni,
    .lvl_i(lvl), .rise_en_i(rise_q), .fall_en_i(fall_q),
    .sel_wr_i(sel_wr), .sw_wr_i(sw_wr), .clr_i(clr),
    .imask_i(imask_q), .emask_i(emask_q),
    .pend_o(pend), .sw_o(swtrig), .irq_o, .evt_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) begin
      case (addr_i)
        REG_IMASK:  rdata_o <= imask_q;
        REG_EMASK:  rdata_o <= emask_q;
        REG_RISE:   rdata_o <= rise_q;
        REG_FALL:   rdata_o <= fall_q;
        REG_SWTRIG: rdata_o <= swtrig;
        REG_PEND:   rdata_o <= pend;
        default:    rdata_o <= '0;
      endcase
    end
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o)); // R11
endmodule

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam logic [31:0] EDGE   = 32'h00FF_FFFF;
  localparam logic [31:0] DIRECT = 32'h0F00_0000;
  localparam logic [31:0] ENW    = EDGE | DIRECT;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] line_i = '0, wdata_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] rdata_o, irq_o, evt_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk_i(clk), .rst_ni, .line_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .evt_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    tick();
    d = rdata_o;
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] rise, fall, lp;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq_o, '0);
    chk("R1 evt", evt_o, '0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv);
      chk("R1 reg", rv, (a == 0) ? DIRECT : '0);
    end

    // R2 writable bits and register map
    wr(3'd0, '1); rd(3'd0, rv); chk("R2 imask", rv, ENW);
    wr(3'd1, '1); rd(3'd1, rv); chk("R2 emask", rv, ENW);
    wr(3'd2, '1); rd(3'd2, rv); chk("R2 rise", rv, EDGE);
    wr(3'd3, '1); rd(3'd3, rv); chk("R2 fall", rv, EDGE);
    wr(3'd7, '1); rd(3'd7, rv); chk("R2 idx7", rv, '0);
    rd(3'd6, rv); chk("R2 idx6", rv, '0);
    rd(3'd2, rv);
    wr(3'd3, '0);
    chk("R11 hold", rdata_o, EDGE);

    // R3/R5/R6/R10 sweep over selects and line patterns
    for (int l = 0; l < 2; l++) begin
      lp = (l == 0) ? 32'hFFFF_FFFF : 32'hF53C_A5F0;
      for (int p = 0; p < 4; p++) begin
        rise = (p == 0 || p == 3) ? EDGE : (p == 2 ? 32'h5555_5555 & EDGE : '0);
        fall = (p == 1 || p == 3) ? EDGE : (p == 2 ? 32'h3333_3333 & EDGE : '0);
        wr(3'd2, rise); wr(3'd3, fall); wr(3'd5, '1);
        line_i = lp;
        tick(); tick();
        chk("R10 direct irq", irq_o, lp & DIRECT);
        chk("R3 latency evt", evt_o, '0);
        tick();
        chk("R3 rise irq", irq_o, (rise & lp) | (lp & DIRECT));
        chk("R6 rise evt", evt_o, (rise & lp) | (lp & DIRECT));
        tick();
        chk("R6 one pulse", evt_o, '0);
        rd(3'd5, rv); chk("R3 rise pend", rv, rise & lp);
        wr(3'd5, '1);
        chk("R4 clr irq", irq_o, lp & DIRECT);
        line_i = '0;
        tick(); tick(); tick();
        chk("R3 fall irq", irq_o, fall & lp);
        chk("R6 fall evt", evt_o, fall & lp);
        tick();
        chk("R6 fall one pulse", evt_o, '0);
        wr(3'd5, '1);
      end
    end

    // R4 write-1-to-clear
    wr(3'd2, EDGE); wr(3'd3, '0);
    line_i = '1; tick(); tick(); tick();
    wr(3'd5, '0); rd(3'd5, rv); chk("R4 write0", rv, EDGE);
    wr(3'd5, 32'h0000_00FF); rd(3'd5, rv); chk("R4 partial", rv, EDGE & ~32'hFF);
    chk("R5 irq", irq_o, (EDGE & ~32'hFF) | DIRECT);

    // R5 mask hides request, flag kept
    wr(3'd0, '0);
    chk("R5 masked", irq_o, '0);
    rd(3'd5, rv); chk("R5 flag kept", rv, EDGE & ~32'hFF);
    wr(3'd0, ENW);
    chk("R5 unmasked", irq_o, (EDGE & ~32'hFF) | DIRECT);
    wr(3'd5, '1);

    // R6 event independent of interrupt enable
    wr(3'd0, '0); wr(3'd3, EDGE);
    line_i = '0; tick(); tick(); tick();
    chk("R6 evt no imask", evt_o, EDGE);
    chk("R6 irq off", irq_o, '0);
    wr(3'd5, '1); wr(3'd0, ENW); wr(3'd3, '0);

    // R7 edge dropped on select write, kept on other write
    line_i = '1; tick(); tick();
    wr(3'd2, EDGE);
    chk("R7 evt dropped", evt_o, DIRECT);
    rd(3'd5, rv); chk("R7 pend dropped", rv, '0);
    line_i = '0; tick(); tick(); tick();
    line_i = '1; tick(); tick();
    wr(3'd1, ENW);
    chk("R7 evt kept", evt_o, ENW);
    rd(3'd5, rv); chk("R7 pend kept", rv, EDGE);
    wr(3'd5, '1);

    // R8 software trigger
    wr(3'd0, ENW & ~32'h100);
    wr(3'd4, 32'hF100_0111);
    chk("R8 sw evt", evt_o, 32'h111);
    chk("R8 sw irq", irq_o, 32'h011 | DIRECT);
    rd(3'd4, rv); chk("R8 sw bits", rv, 32'h111);
    rd(3'd5, rv); chk("R8 sw pend", rv, 32'h011);
    wr(3'd4, 32'h111);
    chk("R8 rewrite no evt", evt_o, '0);
    rd(3'd5, rv); chk("R8 rewrite pend", rv, 32'h011);

    // R9 trigger bit cleared with pending
    wr(3'd5, 32'h001);
    rd(3'd4, rv); chk("R9 partial", rv, 32'h110);
    rd(3'd5, rv); chk("R9 pend left", rv, 32'h010);
    wr(3'd5, '1);
    rd(3'd4, rv); chk("R9 all", rv, '0);

    // R10 direct lines
    wr(3'd0, ENW & ~32'h0100_0000);
    chk("R10 mask", irq_o, DIRECT & ~32'h0100_0000);
    rd(3'd5, rv); chk("R10 no pend", rv, '0);
    line_i = '0; tick(); tick();
    chk("R10 follow low", irq_o, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule